// File: doc/BRIEF.md
# Memory-Mapped Packet Buffer Window

This block is the host-bus side of a network controller's packet memory. A host on a 20-bit legacy bus reaches the controller through a contiguous 4 KB window. The window starts on a 4 KB boundary, and its base number (address bits 19:12) is loaded through a small configuration port. Inside the window the host reads a receive status word, a receive length word and the received frame bytes. It writes outgoing frame bytes into a transmit region. Every transfer finishes in the cycle it is presented, so the ready output never drops.

The receive side of the buffer is filled by the MAC through a plain byte write port, and the MAC also drives the status and length words. The transmit side is drained by the MAC through a plain byte read port. Both sides are addressed buffers and neither moves data as a stream, so there is no back-pressure anywhere. The host bus itself has no wait states, which means the block never stalls a host cycle. The block also enforces the access rules: frame bytes may be read in any order only near the start of a frame, a word access must sit on an even address, and each region accepts only its own direction. Any breach sets a sticky error flag and leaves the buffers unchanged.

Top module: `pbs_mem_slave`

## Requirements
- R1: After reset the block is in I/O mode with window base 0, `acc_err` is 0, `bus_rdata` is 0, every transmit buffer byte reads 0 on `tx_rd_data`, and the receive read pointer is 0.
- R2: `bus_ready` is 1 in every cycle, including during reset.
- R3: Each clock cycle forms one transfer when all of these hold: memory mode is enabled, `bus_cs_n` is 0, `bus_addr[19:12]` equals the configured base, and exactly one of `bus_memr_n` and `bus_memw_n` is 0. If any of these fails, `bus_rdata` is 0, no buffer changes and `acc_err` does not change.
- R4: Window offset `bus_addr[11:0]` = 400h reads `rx_status` and offset 402h reads `rx_length`. A word read (`bus_word`=1) returns the byte at the lower address on `bus_rdata[7:0]`. A byte read returns the addressed byte on `bus_rdata[7:0]` and zero on `bus_rdata[15:8]`.
- R5: A write to any offset from 400h to 9FFh sets `acc_err` and changes nothing.
- R6: Receive frame byte k sits at offset 404h+k. For k below RAND_BYTES (default 118), reads may use any order.
- R7: A receive read whose start index k is at least RAND_BYTES is legal only when k equals the pointer P, or when P is below RAND_BYTES and k equals RAND_BYTES. An illegal read returns the bytes starting at max(P, RAND_BYTES) and sets `acc_err`. Every frame read leaves P at its effective start index plus 1 (byte) or plus 2 (word). A pulse on `rx_frame_start` sets P to 0.
- R8: A write to offset A00h+k stores the byte in transmit byte k, with a word placing `bus_wdata[7:0]` at k and `bus_wdata[15:8]` at k+1. A byte write uses `bus_wdata[7:0]`. Mixed byte and word writes therefore build contiguous frame bytes. Bytes with k at or beyond TX_DEPTH are dropped without error.
- R9: A read from offset A00h or above returns 0 and sets `acc_err`.
- R10: A word access to an odd offset returns 0, changes nothing and sets `acc_err`.
- R11: `acc_err` stays at 1 until `err_clr` is pulsed. Offsets below 400h read as 0 and ignore writes without error.
- R12: When `cfg_we` is 1, the next cycle uses `cfg_mem_en` as the memory-mode enable and `cfg_base` as the window base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load mode and base |
| cfg_mem_en | input | 1 | Memory-mode enable value |
| cfg_base | input | 8 | Window base, address bits 19:12 |
| err_clr | input | 1 | Clears the sticky error flag |
| bus_addr | input | 20 | Host bus address |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_memr_n | input | 1 | Memory read strobe, active low |
| bus_memw_n | input | 1 | Memory write strobe, active low |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, 0 outside a read transfer |
| bus_ready | output | 1 | Transfer ready, always 1 |
| acc_err | output | 1 | Sticky access-rule error |
| rx_wr_en | input | 1 | MAC receive byte write enable |
| rx_wr_addr | input | 8 | MAC receive byte index |
| rx_wr_data | input | 8 | MAC receive byte |
| rx_status | input | 16 | Receive status word |
| rx_length | input | 16 | Receive length word |
| rx_frame_start | input | 1 | New frame, resets the read pointer |
| tx_rd_addr | input | 8 | MAC transmit byte index |
| tx_rd_data | output | 8 | Transmit byte at `tx_rd_addr` |

## Verification
The bench keeps RX_DEPTH at 256 and RAND_BYTES at 118, so real frame bytes exist on both sides of the random-access boundary. Word reads that straddle the boundary, legal sequential reads and skipped-ahead reads past it can all be reached. TX_DEPTH is cut to 16, which puts the end of the transmit buffer within reach of a single write at A10h. That write lets the bench confirm that out-of-range bytes are dropped rather than wrapped onto byte 0.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_STAT,
    RG_LEN,
    RG_RXF,
    RG_TX
  } region_e;
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
  import pbs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int STAT_OFS = 'h400,
  parameter int LEN_OFS  = 'h402,
  parameter int RXF_OFS  = 'h404,
  parameter int TX_OFS   = 'hA00,
  localparam int WIN_W   = 12,
  localparam int BASE_W  = ADDR_W - WIN_W
) (
  input  logic              mem_en,
  input  logic [BASE_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              word,
  output logic              rd_go,
  output logic              wr_go,
  output logic              misalign,
  output region_e           region,
  output logic [WIN_W-1:0]  offs
);
  logic hit;

  assign offs     = addr[WIN_W-1:0];
  assign hit      = mem_en && !cs_n && (addr[ADDR_W-1:WIN_W] == base);
  assign rd_go    = hit && !memr_n && memw_n;
  assign wr_go    = hit && !memw_n && memr_n;
  assign misalign = word && offs[0];

  always_comb begin
    if (offs >= WIN_W'(TX_OFS))       region = RG_TX;
    else if (offs >= WIN_W'(RXF_OFS)) region = RG_RXF;
    else if (offs >= WIN_W'(LEN_OFS)) region = RG_LEN;
    else if (offs >= WIN_W'(STAT_OFS)) region = RG_STAT;
    else                              region = RG_NONE;
  end
endmodule

// File: rtl/pbs_rx_port.sv
module pbs_rx_port #(
  parameter int RX_DEPTH   = 256,
  parameter int RAND_BYTES = 118,
  parameter int RXF_OFS    = 'h404,
  localparam int RX_AW     = $clog2(RX_DEPTH),
  localparam int WIN_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RX_AW-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             frame_start,
  input  logic             rd_go,
  input  logic             word,
  input  logic [WIN_W-1:0] offs,
  output logic [15:0]      rdata,
  output logic             seq_err
);
  logic [7:0]       mem [RX_DEPTH];
  logic [WIN_W-1:0] ptr_q;
  logic [WIN_W-1:0] rel;
  logic [WIN_W-1:0] eff;
  logic [WIN_W-1:0] eff_hi;
  logic             ptr_early;
  logic             legal;

  assign rel       = offs - WIN_W'(RXF_OFS);
  assign ptr_early = ptr_q < WIN_W'(RAND_BYTES);
  assign legal     = (rel < WIN_W'(RAND_BYTES)) || (rel == ptr_q) ||
                     (ptr_early && (rel == WIN_W'(RAND_BYTES)));
  assign eff       = legal ? rel : (ptr_early ? WIN_W'(RAND_BYTES) : ptr_q);
  assign eff_hi    = eff + WIN_W'(1);
  assign seq_err   = rd_go && !legal;

  always_comb begin
    rdata = '0;
    if (rd_go) begin
      rdata[7:0] = mem[eff[RX_AW-1:0]];
      if (word) rdata[15:8] = mem[eff_hi[RX_AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) ptr_q <= '0;
    else if (rd_go) ptr_q <= eff + (word ? WIN_W'(2) : WIN_W'(1));
  end
endmodule

// File: rtl/pbs_tx_port.sv
module pbs_tx_port #(
  parameter int TX_DEPTH = 256,
  parameter int TX_OFS   = 'hA00,
  localparam int TX_AW   = $clog2(TX_DEPTH),
  localparam int WIN_W   = 12,
  localparam int LANES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             word,
  input  logic [WIN_W-1:0] offs,
  input  logic [15:0]      wdata,
  input  logic [TX_AW-1:0] rd_addr,
  output logic [7:0]       rd_data
);
  logic [7:0]       mem [TX_DEPTH];
  logic [WIN_W-1:0] rel;
  logic [LANES-1:0] lane_en;
  logic [TX_AW-1:0] lane_idx [LANES];
  logic [7:0]       lane_dat [LANES];

  assign rel = offs - WIN_W'(TX_OFS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WIN_W-1:0] idx;
    assign idx         = rel + WIN_W'(l);
    assign lane_en[l]  = wr_go && ((l == 0) || word) &&
                         ({1'b0, idx} < (WIN_W + 1)'(TX_DEPTH));
    assign lane_idx[l] = idx[TX_AW-1:0];
    assign lane_dat[l] = wdata[8*l +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TX_DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) mem[lane_idx[l]] <= lane_dat[l];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pbs_mem_slave.sv
module pbs_mem_slave
  import pbs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int RX_DEPTH   = 256,
  parameter int TX_DEPTH   = 256,
  parameter int RAND_BYTES = 118,
  parameter int STAT_OFS   = 'h400,
  parameter int LEN_OFS    = 'h402,
  parameter int RXF_OFS    = 'h404,
  parameter int TX_OFS     = 'hA00,
  localparam int WIN_W     = 12,
  localparam int BASE_W    = ADDR_W - WIN_W,
  localparam int RX_AW     = $clog2(RX_DEPTH),
  localparam int TX_AW     = $clog2(TX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_mem_en,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              err_clr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs_n,
  input  logic              bus_memr_n,
  input  logic              bus_memw_n,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ready,
  output logic              acc_err,
  input  logic              rx_wr_en,
  input  logic [RX_AW-1:0]  rx_wr_addr,
  input  logic [7:0]        rx_wr_data,
  input  logic [15:0]       rx_status,
  input  logic [15:0]       rx_length,
  input  logic              rx_frame_start,
  input  logic [TX_AW-1:0]  tx_rd_addr,
  output logic [7:0]        tx_rd_data
);
  logic              mem_en_q;
  logic [BASE_W-1:0] base_q;
  logic              err_q;
  logic              rd_go, wr_go, misalign;
  region_e           region;
  logic [WIN_W-1:0]  offs;
  logic              rx_rd, tx_wr, seq_err, err_set;
  logic [15:0]       rx_rdata;
  logic [15:0]       reg_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_en_q <= 1'b0;
      base_q   <= '0;
    end else if (cfg_we) begin
      mem_en_q <= cfg_mem_en;
      base_q   <= cfg_base;
    end
  end

  pbs_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .LEN_OFS(LEN_OFS),
    .RXF_OFS(RXF_OFS), .TX_OFS(TX_OFS)
  ) u_dec (
    .mem_en(mem_en_q), .base(base_q), .addr(bus_addr), .cs_n(bus_cs_n),
    .memr_n(bus_memr_n), .memw_n(bus_memw_n), .word(bus_word),
    .rd_go(rd_go), .wr_go(wr_go), .misalign(misalign),
    .region(region), .offs(offs)
  );

  assign rx_rd = rd_go && !misalign && (region == RG_RXF);
  assign tx_wr = wr_go && !misalign && (region == RG_TX);

  pbs_rx_port #(
    .RX_DEPTH(RX_DEPTH), .RAND_BYTES(RAND_BYTES), .RXF_OFS(RXF_OFS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .wr_en(rx_wr_en), .wr_addr(rx_wr_addr),
    .wr_data(rx_wr_data), .frame_start(rx_frame_start), .rd_go(rx_rd),
    .word(bus_word), .offs(offs), .rdata(rx_rdata), .seq_err(seq_err)
  );

  pbs_tx_port #(
    .TX_DEPTH(TX_DEPTH), .TX_OFS(TX_OFS)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_go(tx_wr), .word(bus_word), .offs(offs),
    .wdata(bus_wdata), .rd_addr(tx_rd_addr), .rd_data(tx_rd_data)
  );

  assign reg_word = (region == RG_STAT) ? rx_status : rx_length;

  always_comb begin
    bus_rdata = '0;
    if (rd_go && !misalign) begin
      unique case (region)
        RG_STAT, RG_LEN: bus_rdata = bus_word ? reg_word :
                                     {8'h00, (offs[0] ? reg_word[15:8] : reg_word[7:0])};
        RG_RXF:          bus_rdata = rx_rdata;
        default:         bus_rdata = '0;
      endcase
    end
  end

  assign err_set = ((rd_go || wr_go) && misalign) ||
                   (wr_go && (region == RG_STAT || region == RG_LEN || region == RG_RXF)) ||
                   (rd_go && (region == RG_TX)) ||
                   seq_err;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (err_q && !err_clr) || err_set;
  end

  assign acc_err   = err_q;
  assign bus_ready = 1'b1;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int ADDR_W = 20,
  parameter int TX_OFS = 'hA00,
  localparam int WIN_W  = 12,
  localparam int BASE_W = ADDR_W - WIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_cs_n,
  input logic              bus_memr_n,
  input logic              bus_memw_n,
  input logic              bus_word,
  input logic [15:0]       bus_rdata,
  input logic              bus_ready,
  input logic              acc_err,
  input logic              err_clr,
  input logic              mem_en_q,
  input logic [BASE_W-1:0] base_q
);
  logic sel;
  assign sel = mem_en_q && !bus_cs_n && (bus_addr[ADDR_W-1:WIN_W] == base_q) &&
               (bus_memr_n != bus_memw_n);

  p_ready_high_r2: assert property (@(posedge clk) bus_ready == 1'b1);

  p_cs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> bus_rdata == 16'h0000);

  p_io_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_q && !err_clr) |=> $stable(acc_err));

  p_tx_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !bus_memr_n && bus_addr[WIN_W-1:0] >= WIN_W'(TX_OFS)) |->
      bus_rdata == 16'h0000);

  p_tx_read_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !bus_memr_n && bus_addr[WIN_W-1:0] >= WIN_W'(TX_OFS)) |=> acc_err);

  p_odd_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && bus_word && bus_addr[0]) |=> acc_err);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !err_clr) |=> acc_err);
endmodule

bind pbs_mem_slave pbs_checker #(.ADDR_W(ADDR_W), .TX_OFS(TX_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
  .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n), .bus_word(bus_word),
  .bus_rdata(bus_rdata), .bus_ready(bus_ready), .acc_err(acc_err),
  .err_clr(err_clr), .mem_en_q(mem_en_q), .base_q(base_q)
);

// File: tb/test_pbs_mem_slave.sv
module test_pbs_mem_slave;
  localparam int TXD  = 16;
  localparam logic [7:0] BASE = 8'h3C;
  localparam int NVEC = 19;

  // entry: {write, word, offset[11:0], wdata[15:0], expected rdata[15:0], expected err}
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 12'h400, 16'h0000, 16'hA1B2, 1'b0},  // R4 status word
    {1'b0, 1'b0, 12'h401, 16'h0000, 16'h00A1, 1'b0},  // R4 status high byte
    {1'b0, 1'b1, 12'h402, 16'h0000, 16'h0123, 1'b0},  // R4 length word
    {1'b0, 1'b0, 12'h404, 16'h0000, 16'h005A, 1'b0},  // R6 byte 0
    {1'b0, 1'b1, 12'h40A, 16'h0000, 16'h5D5C, 1'b0},  // R6 bytes 6,7
    {1'b0, 1'b0, 12'h405, 16'h0000, 16'h005B, 1'b0},  // R6 back to byte 1
    {1'b0, 1'b1, 12'h478, 16'h0000, 16'h2F2E, 1'b0},  // R6 bytes 116,117
    {1'b0, 1'b1, 12'h47A, 16'h0000, 16'h2D2C, 1'b0},  // R7 bytes 118,119
    {1'b0, 1'b0, 12'h47C, 16'h0000, 16'h0022, 1'b0},  // R7 byte 120
    {1'b0, 1'b0, 12'h480, 16'h0000, 16'h0023, 1'b1},  // R7 skip to 124 -> 121
    {1'b0, 1'b0, 12'h47E, 16'h0000, 16'h0020, 1'b0},  // R7 byte 122
    {1'b1, 1'b1, 12'h400, 16'hFFFF, 16'h0000, 1'b1},  // R5 write status
    {1'b0, 1'b1, 12'hA00, 16'h0000, 16'h0000, 1'b1},  // R9 read tx
    {1'b0, 1'b1, 12'h403, 16'h0000, 16'h0000, 1'b1},  // R10 odd word
    {1'b1, 1'b1, 12'hA00, 16'h2211, 16'h0000, 1'b0},  // R8 word
    {1'b1, 1'b0, 12'hA02, 16'h0033, 16'h0000, 1'b0},  // R8 even byte
    {1'b1, 1'b0, 12'hA03, 16'h0044, 16'h0000, 1'b0},  // R8 odd byte
    {1'b1, 1'b1, 12'hA04, 16'h6655, 16'h0000, 1'b0},  // R8 word again
    {1'b0, 1'b1, 12'h200, 16'h0000, 16'h0000, 1'b0}   // R11 low offsets
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_mem_en = 1'b0;
  logic [7:0]  cfg_base = '0;
  logic        err_clr = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_cs_n = 1'b1, bus_memr_n = 1'b1, bus_memw_n = 1'b1, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ready, acc_err;
  logic        rx_wr_en = 1'b0;
  logic [7:0]  rx_wr_addr = '0, rx_wr_data = '0;
  logic [15:0] rx_status = 16'hA1B2, rx_length = 16'h0123;
  logic        rx_frame_start = 1'b0;
  logic [3:0]  tx_rd_addr = '0;
  logic [7:0]  tx_rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pbs_mem_slave #(.TX_DEPTH(TXD)) i_pbs_mem_slave (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mem_en(cfg_mem_en),
    .cfg_base(cfg_base), .err_clr(err_clr), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .acc_err(acc_err), .rx_wr_en(rx_wr_en),
    .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data), .rx_status(rx_status),
    .rx_length(rx_length), .rx_frame_start(rx_frame_start),
    .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [7:0] base, input logic wr, input logic word,
                     input logic [11:0] offs, input logic [15:0] wd,
                     output logic [15:0] rd);
    @(negedge clk);
    bus_addr = {base, offs};
    bus_word = word;
    bus_wdata = wd;
    bus_cs_n = 1'b0;
    bus_memr_n = wr;
    bus_memw_n = !wr;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_cs_n = 1'b1;
    bus_memr_n = 1'b1;
    bus_memw_n = 1'b1;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic tx_byte(input int k, input logic [7:0] exp, input string req);
    tx_rd_addr = 4'(k);
    #1 chk(tx_rd_data == exp, req, {8'h00, tx_rd_data}, {8'h00, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state, R2 ready during reset
    chk(bus_ready == 1'b1, "R2", {15'h0, bus_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_err == 1'b0, "R1", {15'h0, acc_err}, 16'h0);
    chk(bus_rdata == 16'h0, "R1", bus_rdata, 16'h0);
    tx_byte(0, 8'h00, "R1");

    // fill receive buffer: byte i = i ^ 5Ah
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rx_wr_en = 1'b1;
      rx_wr_addr = 8'(i);
      rx_wr_data = 8'(i) ^ 8'h5A;
    end
    @(negedge clk);
    rx_wr_en = 1'b0;

    // R3 I/O mode: accesses ignored at base 0
    acc(8'h00, 1'b0, 1'b1, 12'h400, 16'h0, rd);
    chk(rd == 16'h0, "R3", rd, 16'h0);
    acc(8'h00, 1'b1, 1'b1, 12'hA00, 16'hBEEF, rd);
    acc(8'h00, 1'b1, 1'b1, 12'h403, 16'h0, rd);
    chk(acc_err == 1'b0, "R3", {15'h0, acc_err}, 16'h0);
    tx_byte(0, 8'h00, "R3");

    // R12 configure
    @(negedge clk);
    cfg_we = 1'b1; cfg_mem_en = 1'b1; cfg_base = BASE;
    @(negedge clk);
    cfg_we = 1'b0;
    acc(BASE, 1'b0, 1'b1, 12'h402, 16'h0, rd);
    chk(rd == 16'h0123, "R12", rd, 16'h0123);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      acc(BASE, VEC[v][46], VEC[v][45], VEC[v][44:33], VEC[v][32:17], rd);
      chk(rd == VEC[v][16:1], $sformatf("R4-R11 vec %0d rdata", v), rd, VEC[v][16:1]);
      chk(acc_err == VEC[v][0], $sformatf("R5-R11 vec %0d err", v),
          {15'h0, acc_err}, {15'h0, VEC[v][0]});
      if (acc_err) clear_err();
    end

    // R8 contiguous transmit bytes
    tx_byte(0, 8'h11, "R8"); tx_byte(1, 8'h22, "R8"); tx_byte(2, 8'h33, "R8");
    tx_byte(3, 8'h44, "R8"); tx_byte(4, 8'h55, "R8"); tx_byte(5, 8'h66, "R8");

    // R8 write past TX_DEPTH dropped, no wrap, no error
    acc(BASE, 1'b1, 1'b0, 12'hA10, 16'h0099, rd);
    tx_byte(0, 8'h11, "R8 drop");
    chk(acc_err == 1'b0, "R8 drop err", {15'h0, acc_err}, 16'h0);

    // R3 wrong base, chip select high, both strobes
    acc(8'h3D, 1'b0, 1'b1, 12'h400, 16'h0, rd);
    chk(rd == 16'h0, "R3 base", rd, 16'h0);
    @(negedge clk);
    bus_addr = {BASE, 12'h400}; bus_word = 1'b1; bus_memr_n = 1'b0;
    #1 chk(bus_rdata == 16'h0, "R3 cs", bus_rdata, 16'h0);
    bus_cs_n = 1'b0; bus_memw_n = 1'b0; bus_wdata = 16'h7777; bus_addr = {BASE, 12'hA00};
    #1 chk(bus_rdata == 16'h0, "R3 both", bus_rdata, 16'h0);
    @(negedge clk);
    bus_cs_n = 1'b1; bus_memr_n = 1'b1; bus_memw_n = 1'b1;
    tx_byte(0, 8'h11, "R3 both");
    chk(acc_err == 1'b0, "R3 both err", {15'h0, acc_err}, 16'h0);

    // R7 new frame: pointer reset
    @(negedge clk); rx_frame_start = 1'b1;
    @(negedge clk); rx_frame_start = 1'b0;
    acc(BASE, 1'b0, 1'b0, 12'h47A, 16'h0, rd);
    chk(rd == 16'h002C, "R7 restart", rd, 16'h002C);
    chk(acc_err == 1'b0, "R7 restart err", {15'h0, acc_err}, 16'h0);
    acc(BASE, 1'b0, 1'b0, 12'h486, 16'h0, rd);
    chk(rd == 16'h002D, "R7 skip", rd, 16'h002D);

    // R11 sticky until cleared
    repeat (3) @(negedge clk);
    chk(acc_err == 1'b1, "R11 sticky", {15'h0, acc_err}, 16'h1);
    clear_err();
    chk(acc_err == 1'b0, "R11 clear", {15'h0, acc_err}, 16'h0);
    chk(bus_ready == 1'b1, "R2", {15'h0, bus_ready}, 16'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule